// File: doc/BRIEF.md
# System Control and Timekeeping Register Block

This block is a 32-bit register file on a simple memory-mapped slave port. It holds a two-bit LED drive register, a read-only view of synchronised push-button inputs, a general-purpose 32-bit control word, two free-running time counters and a prescaled event counter. A host reads and writes it with a byte address, a write strobe with write data and a read strobe. Read data is registered and becomes valid on the cycle after the read strobe.

The two time counters advance once per second and a hundred times per second. Each has its own divider, sized from the `CLK_HZ` parameter. Software may write either counter at any time. The counter then carries on from the written value, and its divider restarts so the next step comes a full period later. The event counter has a reload register and a phase register. The phase counts down once per clock. Each time it would step from zero, it reloads from the reload register and the event count goes up by one. When the reload value is zero, the event count therefore advances on every clock.

Top module: `ctlio_regs`

## Requirements
- R1: The registers decode on exact byte offsets: 0x00 LED, 0x08 buttons, 0x10 seconds counter, 0x14 centisecond counter, 0x18 event count, 0x1C event reload, 0x20 event phase, 0x4C auxiliary control word. At most one register takes a given write.
- R2: A write to 0x00 keeps only data bits [1:0]. These bits drive `ledOut`. A read returns them with bits [31:2] as zero.
- R3: The auxiliary word at 0x4C stores all 32 written bits and reads them back unchanged.
- R4: The seconds counter at 0x10 increments once every `CLK_HZ` clocks. The centisecond counter at 0x14 increments once every `CLK_HZ/100` clocks. Both wrap modulo 2^32.
- R5: Writing either time counter loads the written value and restarts that counter's divider. The loaded value then holds for exactly one full divider period before its next increment.
- R6: On every clock without a write to it, the phase register behaves as follows. If it is zero, it reloads from the reload register and the event count increments. Otherwise it decrements by one. With a reload of zero, the event count increments every clock.
- R7: Writes to the event count, reload and phase registers load the written value. A write takes precedence over that register's own step in the same cycle. The other registers still step.
- R8: A read at 0x08 returns `btnIn`, zero-extended, through a two-stage synchroniser. A change on the pins becomes readable two clocks later. Writes to 0x08 change nothing.
- R9: A read from any other offset returns zero, including the unaligned offsets. A write to any other offset changes no register.
- R10: Read data is loaded on the clock edge that samples `busRdEn` and holds between reads.
- R11: Reset clears LED, auxiliary word, both time counters, their dividers, event count, reload, phase and read data to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte address of the access |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Registered read data |
| btnIn | input | NUM_BTN | Asynchronous button levels |
| ledOut | output | 2 | LED drive bits |

## Verification
The hardest situation to reach from the ports is a divider restart that lands mid-period. A time counter is written part way through its divider count, and the following increment must come a full period after the write, not at the old phase boundary. The other hard case is an event phase write that collides with a reload. The bench runs long stretches of random writes, reads and idle gaps against a cycle-level reference model, so writes land at every divider phase. It also makes directed writes followed by waits of exactly one period, with reads around the step, and runs the event counter with reload zero and with small reload values.

// File: rtl/ctlio_pkg.sv
package ctlio_pkg;

  localparam int DATA_W = 32;

  localparam logic [11:0] OFS_LED    = 12'h000;
  localparam logic [11:0] OFS_BTN    = 12'h008;
  localparam logic [11:0] OFS_SEC    = 12'h010;
  localparam logic [11:0] OFS_CENTI  = 12'h014;
  localparam logic [11:0] OFS_COUNT  = 12'h018;
  localparam logic [11:0] OFS_RELOAD = 12'h01C;
  localparam logic [11:0] OFS_PHASE  = 12'h020;
  localparam logic [11:0] OFS_AUX    = 12'h04C;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_LED,
    SEL_BTN,
    SEL_SEC,
    SEL_CENTI,
    SEL_COUNT,
    SEL_RELOAD,
    SEL_PHASE,
    SEL_AUX
  } regSel_e;

  typedef struct packed {
    logic    wrLed;
    logic    wrAux;
    logic    wrSec;
    logic    wrCenti;
    logic    wrCount;
    logic    wrReload;
    logic    wrPhase;
    logic    rdFire;
    regSel_e rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/ctlio_ctrl.sv
module ctlio_ctrl
  import ctlio_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output ctlStrobe_t        strb
);

  localparam int CMP_W = (ADDR_W > 12) ? ADDR_W : 12;

  logic [CMP_W-1:0] addrExt;
  regSel_e          sel;

  assign addrExt = CMP_W'(busAddr);

  always_comb begin
    sel = SEL_NONE;
    if      (addrExt == CMP_W'(OFS_LED))    sel = SEL_LED;
    else if (addrExt == CMP_W'(OFS_BTN))    sel = SEL_BTN;
    else if (addrExt == CMP_W'(OFS_SEC))    sel = SEL_SEC;
    else if (addrExt == CMP_W'(OFS_CENTI))  sel = SEL_CENTI;
    else if (addrExt == CMP_W'(OFS_COUNT))  sel = SEL_COUNT;
    else if (addrExt == CMP_W'(OFS_RELOAD)) sel = SEL_RELOAD;
    else if (addrExt == CMP_W'(OFS_PHASE))  sel = SEL_PHASE;
    else if (addrExt == CMP_W'(OFS_AUX))    sel = SEL_AUX;
  end

  always_comb begin
    strb          = '0;
    strb.wrLed    = busWrEn && (sel == SEL_LED);
    strb.wrAux    = busWrEn && (sel == SEL_AUX);
    strb.wrSec    = busWrEn && (sel == SEL_SEC);
    strb.wrCenti  = busWrEn && (sel == SEL_CENTI);
    strb.wrCount  = busWrEn && (sel == SEL_COUNT);
    strb.wrReload = busWrEn && (sel == SEL_RELOAD);
    strb.wrPhase  = busWrEn && (sel == SEL_PHASE);
    strb.rdFire   = busRdEn;
    strb.rdSel    = sel;
  end

  // R1: a single access never lands in two registers
  always_comb begin
    p_single_target_r1: assert ($onehot0({strb.wrLed, strb.wrAux, strb.wrSec, strb.wrCenti,
                                          strb.wrCount, strb.wrReload, strb.wrPhase}))
      else $error("R1: write strobes not one-hot");
  end

endmodule

// File: rtl/ctlio_rate_ctr.sv
module ctlio_rate_ctr
  import ctlio_pkg::*;
#(
  parameter int unsigned DIV = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ld,
  input  logic [DATA_W-1:0] ldVal,
  output logic [DATA_W-1:0] value
);

  localparam int unsigned DIV_W   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0]  divQ;
  logic [DATA_W-1:0] valueQ;
  logic              wrapNow;

  assign wrapNow = (divQ == DIV_LAST);
  assign value   = valueQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ   <= '0;
      valueQ <= '0;
    end else if (ld) begin
      divQ   <= '0;
      valueQ <= ldVal;
    end else if (wrapNow) begin
      divQ   <= '0;
      valueQ <= valueQ + DATA_W'(1);
    end else begin
      divQ   <= divQ + DIV_W'(1);
    end
  end

  p_load_takes_r5: assert property (@(posedge clk) disable iff (!rstN)
    ld |=> (value == $past(ldVal)));

  p_restart_phase_r5: assert property (@(posedge clk) disable iff (!rstN)
    ld |=> (divQ == '0));

  p_hold_between_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ld && !wrapNow) |=> $stable(value));

  p_step_at_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ld && wrapNow) |=> (value == $past(value) + 32'd1));

endmodule

// File: rtl/ctlio_evt_ctr.sv
module ctlio_evt_ctr
  import ctlio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrCount,
  input  logic              wrReload,
  input  logic              wrPhase,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] reload,
  output logic [DATA_W-1:0] phase
);

  logic [DATA_W-1:0] countQ;
  logic [DATA_W-1:0] reloadQ;
  logic [DATA_W-1:0] phaseQ;
  logic              phaseZero;

  assign phaseZero = (phaseQ == '0);
  assign count     = countQ;
  assign reload    = reloadQ;
  assign phase     = phaseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadQ <= '0;
    end else if (wrReload) begin
      reloadQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= '0;
    end else if (wrPhase) begin
      phaseQ <= wrData;
    end else if (phaseZero) begin
      phaseQ <= reloadQ;
    end else begin
      phaseQ <= phaseQ - DATA_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (wrCount) begin
      countQ <= wrData;
    end else if (phaseZero) begin
      countQ <= countQ + DATA_W'(1);
    end
  end

  p_count_on_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!wrCount && phase == '0) |=> (count == $past(count) + 32'd1));

  p_count_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!wrCount && phase != '0) |=> $stable(count));

  p_phase_down_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!wrPhase && phase != '0) |=> (phase == $past(phase) - 32'd1));

  p_phase_write_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrPhase |=> (phase == $past(wrData)));

  p_count_write_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrCount |=> (count == $past(wrData)));

endmodule

// File: rtl/ctlio_datapath.sv
module ctlio_datapath
  import ctlio_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int          NUM_BTN = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_BTN-1:0] btnIn,
  output logic [DATA_W-1:0]  rdData,
  output logic [1:0]         ledOut
);

  localparam int NUM_RATE = 2;

  logic [1:0]         ledQ;
  logic [DATA_W-1:0]  auxQ;
  logic [NUM_BTN-1:0] btnMeta;
  logic [NUM_BTN-1:0] btnSync;
  logic [DATA_W-1:0]  rdNext;
  logic [DATA_W-1:0]  rdQ;

  logic [NUM_RATE-1:0] rateLd;
  logic [DATA_W-1:0]   rateVal [NUM_RATE];

  logic [DATA_W-1:0] evtCount;
  logic [DATA_W-1:0] evtReload;
  logic [DATA_W-1:0] evtPhase;

  assign rateLd = {strb.wrCenti, strb.wrSec};

  generate
    for (genvar i = 0; i < NUM_RATE; i++) begin : g_rate
      localparam int unsigned DIV_I = (i == 0) ? CLK_HZ : CLK_HZ / 100;
      ctlio_rate_ctr #(
        .DIV(DIV_I)
      ) u_rate (
        .clk  (clk),
        .rstN (rstN),
        .ld   (rateLd[i]),
        .ldVal(wrData),
        .value(rateVal[i])
      );
    end
  endgenerate

  ctlio_evt_ctr u_evt (
    .clk     (clk),
    .rstN    (rstN),
    .wrCount (strb.wrCount),
    .wrReload(strb.wrReload),
    .wrPhase (strb.wrPhase),
    .wrData  (wrData),
    .count   (evtCount),
    .reload  (evtReload),
    .phase   (evtPhase)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ledQ <= '0;
      auxQ <= '0;
    end else begin
      if (strb.wrLed) ledQ <= wrData[1:0];
      if (strb.wrAux) auxQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      btnMeta <= '0;
      btnSync <= '0;
    end else begin
      btnMeta <= btnIn;
      btnSync <= btnMeta;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_LED:    rdNext = DATA_W'(ledQ);
      SEL_BTN:    rdNext = DATA_W'(btnSync);
      SEL_SEC:    rdNext = rateVal[0];
      SEL_CENTI:  rdNext = rateVal[1];
      SEL_COUNT:  rdNext = evtCount;
      SEL_RELOAD: rdNext = evtReload;
      SEL_PHASE:  rdNext = evtPhase;
      SEL_AUX:    rdNext = auxQ;
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (strb.rdFire) begin
      rdQ <= rdNext;
    end
  end

  assign rdData = rdQ;
  assign ledOut = ledQ;

  p_led_upper_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdFire && strb.rdSel == SEL_LED) |=> (rdData[DATA_W-1:2] == '0));

  p_led_follows_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrLed |=> (ledOut == $past(wrData[1:0])));

  p_aux_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrAux |=> (auxQ == $past(wrData)));

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdFire && strb.rdSel == SEL_NONE) |=> (rdData == '0));

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdFire |=> $stable(rdData));

endmodule

// File: rtl/ctlio_regs.sv
module ctlio_regs
  import ctlio_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int          NUM_BTN = 2,
  parameter int          ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [31:0]        busWrData,
  input  logic               busRdEn,
  output logic [31:0]        busRdData,
  input  logic [NUM_BTN-1:0] btnIn,
  output logic [1:0]         ledOut
);

  ctlStrobe_t strb;

  ctlio_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .busRdEn(busRdEn),
    .strb   (strb)
  );

  ctlio_datapath #(
    .CLK_HZ (CLK_HZ),
    .NUM_BTN(NUM_BTN)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .wrData(busWrData),
    .btnIn (btnIn),
    .rdData(busRdData),
    .ledOut(ledOut)
  );

endmodule

// File: tb/ctlio_regs_bench.sv
module ctlio_regs_bench;

  localparam int CLK_PERIOD = 10;
  localparam int unsigned HZ = 1000;
  localparam int NB = 4;
  localparam int SEC_DIV = HZ;
  localparam int CEN_DIV = HZ / 100;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [11:0]   busAddr = '0;
  logic          busWrEn = 1'b0;
  logic [31:0]   busWrData = '0;
  logic          busRdEn = 1'b0;
  logic [31:0]   busRdData;
  logic [NB-1:0] btnIn = '0;
  logic [1:0]    ledOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctlio_regs #(.CLK_HZ(HZ), .NUM_BTN(NB), .ADDR_W(12)) u_ctlio_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .btnIn(btnIn), .ledOut(ledOut)
  );

  // Reference model built from the requirements
  logic [1:0]    mLed;
  logic [31:0]   mAux, mSec, mCen, mCnt, mRel, mPh, expRd;
  int            mSecDiv, mCenDiv;
  logic [NB-1:0] mB1, mB2;

  function automatic logic [31:0] modelRead(input logic [11:0] a);
    case (a)
      12'h000: return {30'd0, mLed};
      12'h008: return 32'(mB2);
      12'h010: return mSec;
      12'h014: return mCen;
      12'h018: return mCnt;
      12'h01C: return mRel;
      12'h020: return mPh;
      12'h04C: return mAux;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tagFor(input logic [11:0] a);
    case (a)
      12'h000: return "R2";
      12'h008: return "R8";
      12'h010, 12'h014: return "R4";
      12'h018, 12'h01C, 12'h020: return "R6";
      12'h04C: return "R3";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mLed <= '0; mAux <= '0; mSec <= '0; mCen <= '0; mCnt <= '0;
      mRel <= '0; mPh <= '0; expRd <= '0; mSecDiv <= 0; mCenDiv <= 0;
      mB1 <= '0; mB2 <= '0;
    end else begin
      if (busRdEn) expRd <= modelRead(busAddr);
      mB1 <= btnIn;
      mB2 <= mB1;
      if (busWrEn && busAddr == 12'h000) mLed <= busWrData[1:0];
      if (busWrEn && busAddr == 12'h04C) mAux <= busWrData;
      if (busWrEn && busAddr == 12'h010) begin mSec <= busWrData; mSecDiv <= 0; end
      else if (mSecDiv == SEC_DIV - 1) begin mSec <= mSec + 1; mSecDiv <= 0; end
      else mSecDiv <= mSecDiv + 1;
      if (busWrEn && busAddr == 12'h014) begin mCen <= busWrData; mCenDiv <= 0; end
      else if (mCenDiv == CEN_DIV - 1) begin mCen <= mCen + 1; mCenDiv <= 0; end
      else mCenDiv <= mCenDiv + 1;
      if (busWrEn && busAddr == 12'h01C) mRel <= busWrData;
      if (busWrEn && busAddr == 12'h020) mPh <= busWrData;
      else if (mPh == 0) mPh <= mRel;
      else mPh <= mPh - 1;
      if (busWrEn && busAddr == 12'h018) mCnt <= busWrData;
      else if (mPh == 0) mCnt <= mCnt + 1;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, input string tag);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    chk(busRdData, expRd, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [11:0] pickAddr();
    logic [11:0] m [8] = '{12'h000, 12'h008, 12'h010, 12'h014,
                           12'h018, 12'h01C, 12'h020, 12'h04C};
    if ($urandom_range(0, 4) == 0) return 12'($urandom_range(0, 12'hFFF));
    return m[$urandom_range(0, 7)];
  endfunction

  task automatic finish();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      finish();
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11: reset values
    busRead(12'h000, "R11"); chk(busRdData, 32'd0, "R11");
    busRead(12'h04C, "R11"); chk(busRdData, 32'd0, "R11");
    busRead(12'h01C, "R11");
    busRead(12'h020, "R11");
    busRead(12'h010, "R11");
    chk({30'd0, ledOut}, 32'd0, "R11");

    // R2: only two LED bits kept
    busWrite(12'h000, 32'hFFFF_FFFE);
    busRead(12'h000, "R2"); chk(busRdData, 32'd2, "R2");
    chk({30'd0, ledOut}, 32'd2, "R2");

    // R3: full-width auxiliary word
    busWrite(12'h04C, 32'hA5C3_0F96);
    busRead(12'h04C, "R3");

    // R1/R9: unmapped and unaligned offsets
    busWrite(12'h004, 32'hDEAD_BEEF);
    busWrite(12'h04E, 32'h1234_5678);
    busRead(12'h004, "R9"); chk(busRdData, 32'd0, "R9");
    busRead(12'h011, "R9");
    busRead(12'h04C, "R9");
    busRead(12'h000, "R1");

    // R8: button sync and write ignored
    btnIn = 4'b1011;
    idle(3);
    busWrite(12'h008, 32'hFFFF_FFFF);
    busRead(12'h008, "R8"); chk(busRdData, 32'h0000_000B, "R8");

    // R5: rebase mid-period and watch one full period
    idle(3);
    busWrite(12'h014, 32'hFFFF_FFFE);
    idle(CEN_DIV - 3);
    busRead(12'h014, "R5");
    busRead(12'h014, "R5");
    idle(CEN_DIV);
    busRead(12'h014, "R5");
    busWrite(12'h010, 32'd41);
    idle(SEC_DIV - 2);
    busRead(12'h010, "R5");
    busRead(12'h010, "R5");
    busRead(12'h010, "R4");

    // R6: reload zero counts every clock; small reload divides
    busWrite(12'h01C, 32'd0);
    busWrite(12'h020, 32'd0);
    busWrite(12'h018, 32'd100);
    idle(4);
    busRead(12'h018, "R6");
    busWrite(12'h01C, 32'd3);
    idle(9);
    busRead(12'h018, "R6");
    busRead(12'h020, "R6");

    // R7: phase write overriding a reload
    busWrite(12'h020, 32'd7);
    busRead(12'h020, "R7");
    busWrite(12'h018, 32'hFFFF_FFFF);
    busRead(12'h018, "R7");

    // R10: read data holds
    busRead(12'h04C, "R10");
    held = busRdData;
    idle(5);
    chk(busRdData, held, "R10");

    // Random mix
    for (int i = 0; i < 1500; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 3) busWrite(pickAddr(), $urandom());
      else if (op < 7) begin
        logic [11:0] a = pickAddr();
        busRead(a, tagFor(a));
      end else if (op < 9) idle($urandom_range(1, 25));
      else btnIn = NB'($urandom());
    end

    // R4: long run with no writes
    busWrite(12'h010, 32'd0);
    idle(2 * SEC_DIV);
    busRead(12'h010, "R4");
    busRead(12'h014, "R4");

    finish();
  end

endmodule